// File: doc/BRIEF.md
# I2C Target Register Access Port

This block lets an external I2C controller read and write an internal register space through a 16-bit register pointer. It never generates a clock. SCL and SDA are sampled with the system clock, passed through a two-flop synchronizer, and then filtered so that short spikes are removed. The cleaned lines feed a detector for start, repeated start, stop and SCL edges. A byte engine then walks through the transfer: the device address, two register-address bytes (high byte first), and then data bytes.

After the two address bytes, every further byte written appears as a one-cycle write strobe on the internal register bus. A controller that sends a repeated start followed by the device address with the read bit set receives bytes from the register bus, MSB first. The pointer advances after every byte, so bursts cover consecutive addresses. SDA is open-drain: the block only pulls it low or lets it go. Its 7-bit device address is chosen by a static 3-bit strap.

Top module: `i2creg_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `sda_low` is 0 and neither `reg_wr` nor `reg_rd` is asserted.
- R2: A pulse on `scl_i` or `sda_i` that lasts fewer than FILT_LEN system-clock cycles has no effect on the transfer. The default FILT_LEN is 4, which is 80 ns at 50 MHz and so above 50 ns.
- R3: The device address is 0x2C plus `addr_sel` for strap values 0 to 6. Value 7 selects the same address as 6. When the first byte after a start carries the matching address, the block acknowledges by pulling SDA low during the ninth clock. Bit 0 of that byte is the direction: 0 means write, 1 means read.
- R4: When the address does not match, the block leaves SDA released for the rest of the transfer and raises no strobe until the next start or stop.
- R5: In a write, the two bytes after the address form the pointer (high byte first) and are each acknowledged. Every later byte is acknowledged and produces exactly one `reg_wr` pulse, with `reg_addr` set to the pointer and `reg_wdata` set to the byte.
- R6: The pointer advances by one after each byte written or read, and wraps from 0xFFFF to 0x0000.
- R7: After a repeated start and a matching address with the read bit set, each byte is fetched with one `reg_rd` pulse at the current pointer. `reg_rdata` is taken in the same cycle. The byte is sent MSB first, and a 0 bit pulls SDA low.
- R8: When the controller does not acknowledge a read byte, the block releases SDA, fetches nothing more and stays silent until the next start.
- R9: After a stop, clock pulses without a new start are ignored: no acknowledge and no strobe.
- R10: `sda_low` changes only while SCL is low.
- R11: `reg_wr` and `reg_rd` are single-cycle pulses, are never high together, and occur only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 3 | Static strap that selects the device address |
| scl_i | input | 1 | SCL line as received |
| sda_i | input | 1 | SDA line as received |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 16 | Register pointer |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, sampled in the `reg_rd` cycle |

## Verification
Directed transfers cover the following cases:
- A burst write, then a read-back through a repeated start. These separate pointer loading from pointer advance.
- A burst across 0xFFFF. This exposes a missing wrap.
- Strap values 3, 6 and 7, plus foreign addresses. These show whether the address compare and the clamp of value 7 are right.
- A read ended by a not-acknowledge, then extra clocks. This shows whether the engine really stops.
- Bytes clocked after a stop with no start. This shows whether idle is really idle.
- A write with 3-cycle spikes on SCL and SDA while SCL is high. If the filter leaks, an extra bit or a false start appears.

Seeded random bursts of random length, address and data, each written and then read back, cover the general case. They are checked against a model of the register space kept inside the bench.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_RHI,
        ST_RLO,
        ST_WR,
        ST_RD
    } phase_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam logic [6:0] DEV_BASE = 7'h2C;

    function automatic logic [6:0] dev_addr(input logic [2:0] sel);
        logic [2:0] s;
        s = (sel == 3'd7) ? 3'd6 : sel;
        return DEV_BASE + {4'b0000, s};
    endfunction

endpackage

// File: rtl/i2creg_glitch.sv
module i2creg_glitch #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
            dout <= 1'b1;
            cnt  <= '0;
        end else begin
            sync <= {sync[0], din};
            if (sync[1] == dout) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                dout <= sync[1];
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2creg_cond.sv
module i2creg_cond
    import i2creg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.sda      = sda;
        ev.scl_rise = scl & ~scl_q;
        ev.scl_fall = ~scl & scl_q;
        ev.start    = scl & scl_q & sda_q & ~sda;
        ev.stop     = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/i2creg_engine.sv
module i2creg_engine
    import i2creg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  addr_sel,
    input  bus_ev_t     ev,
    output logic        sda_low,
    output logic [15:0] reg_addr,
    output logic [7:0]  reg_wdata,
    output logic        reg_wr,
    output logic        reg_rd,
    input  logic [7:0]  reg_rdata
);
    phase_e      st;
    logic [3:0]  bcnt;
    logic        ackph;
    logic        rnw;
    logic [7:0]  shreg;
    logic [15:0] ptr;
    logic        drv;

    logic byte_done, rx_state, dev_hit, load;

    always_comb begin
        byte_done = ev.scl_fall && !ackph && (bcnt == 4'd8);
        rx_state  = (st == ST_DEV) || (st == ST_RHI) || (st == ST_RLO) || (st == ST_WR);
        dev_hit   = (shreg[7:1] == dev_addr(addr_sel));
        load      = ev.scl_fall && ackph && (((st == ST_DEV) && rnw) || (st == ST_RD));
    end

    assign reg_wr    = (st == ST_WR) && byte_done;
    assign reg_rd    = load;
    assign reg_addr  = ptr;
    assign reg_wdata = shreg;
    assign sda_low   = drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            bcnt  <= '0;
            ackph <= 1'b0;
            rnw   <= 1'b0;
            shreg <= '0;
            ptr   <= '0;
            drv   <= 1'b0;
        end else if (ev.start) begin
            st    <= ST_DEV;
            bcnt  <= '0;
            ackph <= 1'b0;
            drv   <= 1'b0;
        end else if (ev.stop) begin
            st    <= ST_IDLE;
            ackph <= 1'b0;
            drv   <= 1'b0;
        end else if (load) begin
            shreg <= reg_rdata;
            drv   <= ~reg_rdata[7];
            ptr   <= ptr + 16'd1;
            ackph <= 1'b0;
            bcnt  <= '0;
            st    <= ST_RD;
        end else if (rx_state) begin
            if (ev.scl_rise && !ackph && (bcnt < 4'd8)) begin
                shreg <= {shreg[6:0], ev.sda};
                bcnt  <= bcnt + 4'd1;
            end
            if (byte_done) begin
                bcnt  <= '0;
                ackph <= 1'b1;
                drv   <= 1'b1;
                unique case (st)
                    ST_DEV: begin
                        if (!dev_hit) begin
                            st    <= ST_IDLE;
                            drv   <= 1'b0;
                            ackph <= 1'b0;
                        end else begin
                            rnw <= shreg[0];
                        end
                    end
                    ST_RHI:  ptr[15:8] <= shreg;
                    ST_RLO:  ptr[7:0]  <= shreg;
                    ST_WR:   ptr       <= ptr + 16'd1;
                    default: ;
                endcase
            end else if (ev.scl_fall && ackph) begin
                drv   <= 1'b0;
                ackph <= 1'b0;
                unique case (st)
                    ST_DEV:  st <= ST_RHI;
                    ST_RHI:  st <= ST_RLO;
                    ST_RLO:  st <= ST_WR;
                    default: ;
                endcase
            end
        end else if (st == ST_RD) begin
            if (!ackph) begin
                if (ev.scl_rise) bcnt <= bcnt + 4'd1;
                if (ev.scl_fall) begin
                    if (bcnt == 4'd8) begin
                        drv   <= 1'b0;
                        ackph <= 1'b1;
                    end else begin
                        shreg <= {shreg[6:0], 1'b0};
                        drv   <= ~shreg[6];
                    end
                end
            end else if (ev.scl_rise && ev.sda) begin
                st    <= ST_IDLE;
                ackph <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2creg_port.sv
module i2creg_port
    import i2creg_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  addr_sel,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_low,
    output logic [15:0] reg_addr,
    output logic [7:0]  reg_wdata,
    output logic        reg_wr,
    output logic        reg_rd,
    input  logic [7:0]  reg_rdata
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw, filt;
    logic              scl_f, sda_f;
    bus_ev_t           ev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2creg_glitch #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[g]),
            .dout (filt[g])
        );
    end

    assign scl_f = filt[0];
    assign sda_f = filt[1];

    i2creg_cond u_cond (
        .clk (clk),
        .rst (rst),
        .scl (scl_f),
        .sda (sda_f),
        .ev  (ev)
    );

    i2creg_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .addr_sel  (addr_sel),
        .ev        (ev),
        .sda_low   (sda_low),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: rtl/i2creg_port_checker.sv
module i2creg_port_checker (
    input logic        clk,
    input logic        rst,
    input logic        scl_f,
    input logic        sda_low,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [15:0] reg_addr
);
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    a_r11_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    a_r11_rd_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    a_r11_strobe_scl_low: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd) |-> !scl_f);

    a_r6_ptr_after_wr: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_addr == $past(reg_addr) + 16'd1));

    a_r6_ptr_after_rd: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> (reg_addr == $past(reg_addr) + 16'd1));

    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> !scl_f);
endmodule

bind i2creg_port i2creg_port_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_f),
    .sda_low  (sda_low),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr)
);

// File: tb/i2creg_port_bench.sv
module i2creg_port_bench;
    localparam int Q = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr_sel = 3'd0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_low;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_rdata;
    wire         sda_line = sda_m & ~sda_low;

    always #10 clk = ~clk;

    i2creg_port u_i2creg_port (
        .clk       (clk),
        .rst       (rst),
        .addr_sel  (addr_sel),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_low   (sda_low),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    logic [7:0]  mem [0:255];
    logic [7:0]  expm [0:255];
    logic [15:0] lg_a [0:255];
    logic [7:0]  lg_d [0:255];
    logic [7:0]  wbuf [0:7];
    logic [7:0]  rbuf [0:7];
    int lg_n = 0, rd_n = 0, drv_n = 0, r10_bad = 0, r11_bad = 0;
    int nchk = 0, nfail = 0, glitch_kind = 0;
    bit done = 0, prev_drv = 0, prev_wr = 0, prev_rd = 0;

    assign reg_rdata = mem[reg_addr[7:0]];

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 29 + 7);
    endfunction

    function automatic logic [6:0] exp_dev(input logic [2:0] sel);
        return 7'h2C + 7'((sel == 3'd7) ? 6 : int'(sel));
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]  = init_val(i);
            expm[i] = init_val(i);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr) begin
                if (lg_n < 256) begin
                    lg_a[lg_n] = reg_addr;
                    lg_d[lg_n] = reg_wdata;
                end
                lg_n++;
                mem[reg_addr[7:0]] = reg_wdata;
            end
            if (reg_rd) rd_n++;
            if (sda_low) drv_n++;
            if ((sda_low != prev_drv) && scl_m) r10_bad++;
            if ((reg_wr && reg_rd) || (reg_wr && prev_wr) || (reg_rd && prev_rd)) r11_bad++;
        end
        prev_drv = sda_low;
        prev_wr  = reg_wr;
        prev_rd  = reg_rd;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic bit_tx(input logic b, output logic r);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        r = sda_line;
        if (glitch_kind == 1) begin
            scl_m = 1'b0; tick(3); scl_m = 1'b1;
        end else if (glitch_kind == 2) begin
            sda_m = ~b; tick(3); sda_m = b;
        end
        if (glitch_kind != 0) begin
            glitch_kind = 0;
            tick(Q - 3);
        end else begin
            tick(Q);
        end
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_tx(b[i], r);
        bit_tx(1'b1, ack);
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] b);
        logic r;
        for (int i = 0; i < 8; i++) begin
            bit_tx(1'b1, r);
            b = {b[6:0], r};
        end
        bit_tx(nack, r);
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [15:0] a,
                            input int n, input bit gl, output int nacks);
        logic k;
        nacks = 0;
        bus_start();
        wbyte({dev, 1'b0}, k); nacks += int'(k);
        wbyte(a[15:8], k);     nacks += int'(k);
        wbyte(a[7:0], k);      nacks += int'(k);
        for (int i = 0; i < n; i++) begin
            if (gl && i == 0) glitch_kind = 1;
            if (gl && i == 1) glitch_kind = 2;
            wbyte(wbuf[i], k); nacks += int'(k);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] dev, input logic [15:0] a,
                           input int n, output int nacks);
        logic k;
        nacks = 0;
        bus_start();
        wbyte({dev, 1'b0}, k); nacks += int'(k);
        wbyte(a[15:8], k);     nacks += int'(k);
        wbyte(a[7:0], k);      nacks += int'(k);
        bus_start();
        wbyte({dev, 1'b1}, k); nacks += int'(k);
        for (int i = 0; i < n; i++) rbyte(i == n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic check_log(input int base, input logic [15:0] a, input int n,
                             input string req);
        chk(lg_n == base + n, req, "write count", lg_n, base + n);
        for (int i = 0; i < n; i++) begin
            chk(lg_a[base + i] == a + 16'(i), "R6", "write address",
                int'(lg_a[base + i]), int'(a + 16'(i)));
            chk(lg_d[base + i] == wbuf[i], req, "write data",
                int'(lg_d[base + i]), int'(wbuf[i]));
            expm[8'(a + 16'(i))] = wbuf[i];
        end
    endtask

    task automatic check_read(input logic [15:0] a, input int n, input int rd0,
                              input string req);
        chk(rd_n == rd0 + n, req, "read strobes", rd_n, rd0 + n);
        for (int i = 0; i < n; i++)
            chk(rbuf[i] == expm[8'(a + 16'(i))], req, "read data",
                int'(rbuf[i]), int'(expm[8'(a + 16'(i))]));
    endtask

    task automatic do_reset(input logic [2:0] sel);
        rst = 1'b1;
        addr_sel = sel;
        tick(5);
        rst = 1'b0;
        tick(Q);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int na, base, rd0, dn, n;
        logic k;
        logic [15:0] a;
        logic [7:0] b;
        logic [2:0] sels [0:2];

        tick(3);
        // R1: reset state
        chk(sda_low == 1'b0, "R1", "sda_low in reset", int'(sda_low), 0);
        chk(!reg_wr && !reg_rd, "R1", "strobes in reset", int'({reg_wr, reg_rd}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sda_low == 1'b0 && !reg_wr && !reg_rd, "R1", "after reset",
            int'({sda_low, reg_wr, reg_rd}), 0);
        tick(Q);

        // R5, R3: burst write
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h00;
        base = lg_n;
        do_write(exp_dev(3'd0), 16'h0010, 3, 0, na);
        chk(na == 0, "R3", "acks on write", na, 0);
        check_log(base, 16'h0010, 3, "R5");

        // R7: read back through repeated start
        rd0 = rd_n;
        do_read(exp_dev(3'd0), 16'h000F, 4, na);
        chk(na == 0, "R7", "acks on read", na, 0);
        check_read(16'h000F, 4, rd0, "R7");

        // R6: wrap of the pointer
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        base = lg_n;
        do_write(exp_dev(3'd0), 16'hFFFF, 2, 0, na);
        check_log(base, 16'hFFFF, 2, "R6");
        chk(lg_a[base + 1] == 16'h0000, "R6", "wrap address", int'(lg_a[base + 1]), 0);

        // R3 / R4: strap values and foreign addresses
        sels[0] = 3'd3; sels[1] = 3'd6; sels[2] = 3'd7;
        for (int s = 0; s < 3; s++) begin
            do_reset(sels[s]);
            wbuf[0] = 8'(8'h40 + s);
            base = lg_n;
            do_write(exp_dev(sels[s]), 16'h0040, 1, 0, na);
            chk(na == 0, "R3", "strap match acks", na, 0);
            check_log(base, 16'h0040, 1, "R3");
            base = lg_n;
            dn = drv_n;
            do_write(exp_dev(sels[s]) + 7'd1, 16'h0041, 2, 0, na);
            chk(na == 5, "R4", "foreign address nacks", na, 5);
            chk(lg_n == base, "R4", "no write on mismatch", lg_n, base);
            chk(drv_n == dn, "R4", "sda untouched on mismatch", drv_n - dn, 0);
        end
        do_reset(3'd0);

        // R8: not-acknowledge ends the read
        rd0 = rd_n;
        do_read(exp_dev(3'd0), 16'h0020, 2, na);
        check_read(16'h0020, 2, rd0, "R8");
        rd0 = rd_n;
        dn = drv_n;
        bus_start();
        wbyte({exp_dev(3'd0), 1'b1}, k);
        chk(k == 1'b0, "R8", "read address ack", int'(k), 0);
        rbyte(1'b1, b);
        chk(b == expm[8'h22], "R8", "byte before nack", int'(b), int'(expm[8'h22]));
        dn = drv_n;
        rbyte(1'b0, b);
        chk(b == 8'hFF, "R8", "released after nack", int'(b), 255);
        chk(rd_n == rd0 + 1, "R8", "no fetch after nack", rd_n, rd0 + 1);
        chk(drv_n == dn, "R8", "sda idle after nack", drv_n - dn, 0);
        bus_stop();

        // R9: clocking after a stop without start
        base = lg_n;
        scl_m = 1'b0; tick(Q);
        wbyte({exp_dev(3'd0), 1'b0}, k);
        chk(k == 1'b1, "R9", "no ack after stop", int'(k), 1);
        wbyte(8'h00, k);
        wbyte(8'h50, k);
        wbyte(8'h77, k);
        chk(lg_n == base, "R9", "no write after stop", lg_n, base);
        bus_stop();

        // R2: spikes on SCL and SDA during data bits
        wbuf[0] = 8'hC3; wbuf[1] = 8'h5A;
        base = lg_n;
        do_write(exp_dev(3'd0), 16'h0060, 2, 1, na);
        chk(na == 0, "R2", "acks with spikes", na, 0);
        check_log(base, 16'h0060, 2, "R2");

        // Random bursts: R5, R6, R7
        void'($urandom(32'd20240611));
        for (int t = 0; t < 10; t++) begin
            a = 16'($urandom);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            base = lg_n;
            do_write(exp_dev(3'd0), a, n, 0, na);
            chk(na == 0, "R5", "random write acks", na, 0);
            check_log(base, a, n, "R5");
            rd0 = rd_n;
            do_read(exp_dev(3'd0), a, n, na);
            chk(na == 0, "R7", "random read acks", na, 0);
            check_read(a, n, rd0, "R7");
        end

        // R10, R11: monitors across the whole run
        chk(r10_bad == 0, "R10", "sda changes while scl high", r10_bad, 0);
        chk(r11_bad == 0, "R11", "strobe overlap or width", r11_bad, 0);

        finish_run();
    end
endmodule